// File: doc/BRIEF.md
# Coalescing Line Write Buffer

This block sits between a core's store port and the memory write path. Each store carries a word address and one data word. The block groups stores by cache line. A store to a line that already has a pending entry is folded into that entry. Otherwise it takes a free entry. Each store is acknowledged in the cycle it is offered, so the core never waits for memory.

Each entry keeps a line address, one data word per word slot and a written-word mask. Entries leave in the order they were allocated. Each one leaves as a single-beat, whole-line write that carries the line address, every word slot and the mask. Merging pulls later stores forward into older entries, so stores to different lines can reach memory out of program order. This relaxation matches partial store ordering. Raising the fence input blocks new stores until everything pending has been written out.

Top module: `line_merge_wbuf`

## Requirements
- R1: After reset no memory write is offered, `st_ready_o` is high, and `fence_done_o` is low while `fence_i` is low.
- R2: With `fence_i` low and a free entry or a matching entry present, a store is accepted in the cycle `st_valid_i` is high (`st_ready_o` high in that cycle).
- R3: Two stores to different words of the same line, both accepted before that line is handed to memory, produce exactly one memory write whose mask has both word bits set.
- R4: A second store to the same word of a pending line replaces the earlier data. The memory write shows the later data and a single mask bit for that word.
- R5: Entries are written out oldest-allocated first. For stores to lines X, Y, X in that order while memory is stalled, memory receives the merged X write and then the Y write, so Y never falls between the two X stores.
- R6: Word index = address bits [WOFF-1:0] and line address = address bits [ADDR_W-1:WOFF], where WOFF = log2(WORDS). Word i appears at `mem_data_o[i*DATA_W +: DATA_W]` with mask bit i set. Word slots never written in an entry read as zero.
- R7: A store that matches the line being accepted by memory in that same cycle (`mem_valid_o` and `mem_ready_i` both high) does not merge. It allocates a new entry, which gives a second memory write for that line.
- R8: When all entries are occupied and none matches the store's line, `st_ready_o` is low until an entry drains. A store that matches an occupied entry is still accepted.
- R9: While `fence_i` is high, stores are not accepted. `fence_done_o` rises only once every entry has been written out, and at that point `mem_valid_o` is low.
- R10: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_line_o` holds its value. Merges may only add mask bits; they never remove one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| st_valid_i | input | 1 | Store request |
| st_ready_o | output | 1 | Store accepted this cycle |
| st_addr_i | input | ADDR_W | Word address of the store |
| st_data_i | input | DATA_W | Store data |
| fence_i | input | 1 | Block stores and drain everything |
| fence_done_o | output | 1 | Fence raised and buffer empty |
| mem_valid_o | output | 1 | Line write offered to memory |
| mem_ready_i | input | 1 | Memory accepts the offered write |
| mem_line_o | output | ADDR_W-WOFF | Line address of the write |
| mem_data_o | output | WORDS*DATA_W | All word slots of the line |
| mem_mask_o | output | WORDS | Written-word mask |

## Verification
The bench stalls memory while it issues X, Y, X store patterns. A buffer that drained in program order, or that failed to merge, would emit three writes or place Y between the X stores. It times a same-line store to land in exactly the cycle memory accepts that line. A design that merged into the departing entry would silently drop the second word. It fills every entry and then checks that a store to a new line stalls while a store to an occupied line still goes through. A design that counted the merge as needing a slot would deadlock, and one that ignored fullness would overwrite a pending entry. A fence is held with a store waiting behind it. Completion that came early, or a store that slipped through, shows up as an extra or premature memory write.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
  localparam int unsigned DEF_ENTRIES = 4;
  localparam int unsigned DEF_WORDS   = 4;
  localparam int unsigned DEF_DATA_W  = 32;
  localparam int unsigned DEF_ADDR_W  = 16;

  function automatic int unsigned ptr_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lwb_entry.sv
module lwb_entry #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LINE_W = 14,
  parameter int unsigned WIDX_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    alloc_i,
  input  logic                    merge_i,
  input  logic                    clear_i,
  input  logic [LINE_W-1:0]       line_i,
  input  logic [WIDX_W-1:0]       widx_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic                    valid_o,
  output logic [LINE_W-1:0]       line_o,
  output logic [WORDS*DATA_W-1:0] data_o,
  output logic [WORDS-1:0]        mask_o
);
  logic                         valid_q;
  logic [LINE_W-1:0]            line_q;
  logic [WORDS-1:0][DATA_W-1:0] data_q;
  logic [WORDS-1:0]             mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      line_q  <= '0;
      data_q  <= '0;
      mask_q  <= '0;
    end else begin
      if (clear_i) begin
        valid_q <= 1'b0;
        mask_q  <= '0;
      end
      if (alloc_i) begin
        valid_q <= 1'b1;
        line_q  <= line_i;
      end
      for (int w = 0; w < WORDS; w++) begin
        if (alloc_i) begin
          data_q[w] <= (WIDX_W'(w) == widx_i) ? data_i : '0;
          mask_q[w] <= (WIDX_W'(w) == widx_i);
        end else if (merge_i && WIDX_W'(w) == widx_i) begin
          data_q[w] <= data_i;
          mask_q[w] <= 1'b1;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign line_o  = line_q;
  assign data_o  = data_q;
  assign mask_o  = mask_q;

  // R8: a slot is only claimed when free
  a_r8_alloc_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !valid_q);
  // R3: merges only land on live entries
  a_r3_merge_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_i |-> valid_q && !clear_i);
endmodule

// File: rtl/lwb_order.sv
module lwb_order #(
  parameter int unsigned NUM_ENT = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam int unsigned CNT_W = IDX_W + 1;

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(NUM_ENT - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= bump(tail_q);
      if (pop_i)  head_q <= bump(head_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign full_o  = (cnt_q == CNT_W'(NUM_ENT));
  assign empty_o = (cnt_q == '0);

  // R8: never allocate beyond capacity
  a_r8_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q < CNT_W'(NUM_ENT));
  // R5: drains only pop live entries
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/lwb_match.sv
module lwb_match #(
  parameter int unsigned NUM_ENT = 4,
  parameter int unsigned LINE_W  = 14,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [NUM_ENT-1:0]        valid_i,
  input  logic [NUM_ENT-1:0]        excl_i,
  input  logic [NUM_ENT*LINE_W-1:0] lines_i,
  input  logic [LINE_W-1:0]         line_i,
  output logic [NUM_ENT-1:0]        hit_vec_o,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          hit_idx_o
);
  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    assign hit_vec_o[i] = valid_i[i] & ~excl_i[i] &
                          (lines_i[i*LINE_W +: LINE_W] == line_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (hit_vec_o[i]) hit_idx_o = IDX_W'(i);
  end

  assign hit_o = |hit_vec_o;
endmodule

// File: rtl/line_merge_wbuf.sv
module line_merge_wbuf
  import lwb_pkg::*;
#(
  parameter int unsigned NUM_ENT = DEF_ENTRIES,
  parameter int unsigned WORDS   = DEF_WORDS,
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  localparam int unsigned WOFF_W = ptr_w(WORDS),
  localparam int unsigned LINE_W = ADDR_W - WOFF_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    st_valid_i,
  output logic                    st_ready_o,
  input  logic [ADDR_W-1:0]       st_addr_i,
  input  logic [DATA_W-1:0]       st_data_i,
  input  logic                    fence_i,
  output logic                    fence_done_o,
  output logic                    mem_valid_o,
  input  logic                    mem_ready_i,
  output logic [LINE_W-1:0]       mem_line_o,
  output logic [WORDS*DATA_W-1:0] mem_data_o,
  output logic [WORDS-1:0]        mem_mask_o
);
  localparam int unsigned IDX_W = ptr_w(NUM_ENT);

  logic [NUM_ENT-1:0]        ent_valid;
  logic [LINE_W-1:0]         ent_line [NUM_ENT];
  logic [WORDS*DATA_W-1:0]   ent_data [NUM_ENT];
  logic [WORDS-1:0]          ent_mask [NUM_ENT];
  logic [NUM_ENT*LINE_W-1:0] lines_flat;

  logic [IDX_W-1:0]   head_idx, tail_idx, hit_idx;
  logic               full, empty, hit, mem_fire, st_fire, push;
  logic [NUM_ENT-1:0] excl, hit_vec, alloc_vec, merge_vec, clear_vec;

  wire [LINE_W-1:0] st_line = st_addr_i[ADDR_W-1:WOFF_W];
  wire [WOFF_W-1:0] st_widx = st_addr_i[WOFF_W-1:0];

  assign mem_valid_o = ent_valid[head_idx];
  assign mem_line_o  = ent_line[head_idx];
  assign mem_data_o  = ent_data[head_idx];
  assign mem_mask_o  = ent_mask[head_idx];
  assign mem_fire    = mem_valid_o & mem_ready_i;

  // the entry being handed off this cycle is closed to merges
  assign excl = mem_fire ? (NUM_ENT'(1) << head_idx) : '0;

  lwb_match #(.NUM_ENT(NUM_ENT), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_match (
    .valid_i  (ent_valid),
    .excl_i   (excl),
    .lines_i  (lines_flat),
    .line_i   (st_line),
    .hit_vec_o(hit_vec),
    .hit_o    (hit),
    .hit_idx_o(hit_idx)
  );

  assign st_ready_o   = ~fence_i & (hit | ~full);
  assign st_fire      = st_valid_i & st_ready_o;
  assign push         = st_fire & ~hit;
  assign alloc_vec    = push ? (NUM_ENT'(1) << tail_idx) : '0;
  assign merge_vec    = (st_fire & hit) ? (NUM_ENT'(1) << hit_idx) : '0;
  assign clear_vec    = excl;
  assign fence_done_o = fence_i & empty;

  lwb_order #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_order (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push),
    .pop_i  (mem_fire),
    .head_o (head_idx),
    .tail_o (tail_idx),
    .full_o (full),
    .empty_o(empty)
  );

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    lwb_entry #(
      .WORDS(WORDS), .DATA_W(DATA_W), .LINE_W(LINE_W), .WIDX_W(WOFF_W)
    ) u_entry (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .alloc_i(alloc_vec[e]),
      .merge_i(merge_vec[e]),
      .clear_i(clear_vec[e]),
      .line_i (st_line),
      .widx_i (st_widx),
      .data_i (st_data_i),
      .valid_o(ent_valid[e]),
      .line_o (ent_line[e]),
      .data_o (ent_data[e]),
      .mask_o (ent_mask[e])
    );
    assign lines_flat[e*LINE_W +: LINE_W] = ent_line[e];
  end

  // R3: at most one open entry per line
  a_r3_single_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  // R10: offered line held while memory stalls
  a_r10_line_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_line_o));
  // R10: mask of a stalled offer only grows
  a_r10_mask_grow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> ($past(mem_mask_o) & ~mem_mask_o) == '0);
  // R6: every offered write carries at least one word
  a_r6_mask_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_mask_o != '0);
  // R9: completion only with nothing left to offer
  a_r9_done_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fence_done_o |-> !mem_valid_o);
endmodule

// File: tb/line_merge_wbuf_bench.sv
module line_merge_wbuf_bench;
  localparam int DW = 32;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          st_valid = 1'b0, st_ready;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          fence = 1'b0, fence_done;
  logic          mem_valid, mem_ready = 1'b0;
  logic [13:0]   mem_line;
  logic [127:0]  mem_data;
  logic [3:0]    mem_mask;

  int n_chk = 0, n_bad = 0;

  logic [13:0]  rec_line [32];
  logic [127:0] rec_data [32];
  logic [3:0]   rec_mask [32];
  int           rec_n = 0;

  always #4 clk = ~clk;

  line_merge_wbuf u_line_merge_wbuf (
    .clk_i(clk), .rst_ni(rst_n),
    .st_valid_i(st_valid), .st_ready_o(st_ready),
    .st_addr_i(st_addr), .st_data_i(st_data),
    .fence_i(fence), .fence_done_o(fence_done),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready),
    .mem_line_o(mem_line), .mem_data_o(mem_data), .mem_mask_o(mem_mask)
  );

  // record each accepted line write just before the edge that takes it
  always @(negedge clk) begin
    #3;
    if (rst_n && mem_valid && mem_ready && rec_n < 32) begin
      rec_line[rec_n] = mem_line;
      rec_data[rec_n] = mem_data;
      rec_mask[rec_n] = mem_mask;
      rec_n++;
    end
  end

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic first_ok);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    #3;
    first_ok = st_ready;
    while (!st_ready) begin
      @(negedge clk);
      #3;
    end
    @(posedge clk);
    #1 st_valid = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic flush_and_reset_rec();
    cycles(1);
    rec_n = 0;
  endtask

  function automatic logic [127:0] line4(input logic [31:0] w3, w2, w1, w0);
    return {w3, w2, w1, w0};
  endfunction

  task automatic t_reset();
    cycles(1);
    #3;
    chk("R1 mem_valid", mem_valid, 1'b0);
    chk("R1 st_ready", st_ready, 1'b1);
    chk("R1 fence_done", fence_done, 1'b0);
  endtask

  task automatic t_merge();
    logic ok;
    flush_and_reset_rec();
    mem_ready = 1'b0;
    store(16'h0040, 32'hAAAA0001, ok);
    chk("R2 accept first", ok, 1'b1);
    store(16'h0042, 32'hBBBB0002, ok);
    chk("R2 accept merge", ok, 1'b1);
    @(negedge clk) mem_ready = 1'b1;
    cycles(4);
    chk("R3 one write", rec_n, 1);
    chk("R6 line", rec_line[0], 14'h010);
    chk("R3 mask", rec_mask[0], 4'b0101);
    chk("R6 data", rec_data[0], line4(0, 32'hBBBB0002, 0, 32'hAAAA0001));
  endtask

  task automatic t_overwrite();
    logic ok;
    flush_and_reset_rec();
    mem_ready = 1'b0;
    store(16'h0081, 32'h11111111, ok);
    store(16'h0081, 32'h22222222, ok);
    @(negedge clk) mem_ready = 1'b1;
    cycles(4);
    chk("R4 one write", rec_n, 1);
    chk("R4 mask", rec_mask[0], 4'b0010);
    chk("R4 data", rec_data[0], line4(0, 0, 32'h22222222, 0));
  endtask

  task automatic t_pso();
    logic ok;
    flush_and_reset_rec();
    mem_ready = 1'b0;
    store(16'h0100, 32'hC0C00000, ok);
    store(16'h0200, 32'hD0D00000, ok);
    store(16'h0103, 32'hC0C00003, ok);
    @(negedge clk) mem_ready = 1'b1;
    cycles(5);
    chk("R5 writes", rec_n, 2);
    chk("R5 first line", rec_line[0], 14'h040);
    chk("R5 first mask", rec_mask[0], 4'b1001);
    chk("R5 first data", rec_data[0], line4(32'hC0C00003, 0, 0, 32'hC0C00000));
    chk("R5 second line", rec_line[1], 14'h080);
    chk("R5 second mask", rec_mask[1], 4'b0001);
  endtask

  task automatic t_stable();
    logic ok;
    logic [13:0] l0;
    flush_and_reset_rec();
    mem_ready = 1'b0;
    store(16'h0400, 32'hE0000000, ok);
    cycles(1);
    #3;
    l0 = mem_line;
    chk("R10 valid held", mem_valid, 1'b1);
    store(16'h0402, 32'hF0000000, ok);
    cycles(1);
    #3;
    chk("R10 line held", mem_line, l0);
    chk("R10 mask grows", mem_mask, 4'b0101);
    chk("R10 old word", mem_data[31:0], 32'hE0000000);
    @(negedge clk) mem_ready = 1'b1;
    cycles(4);
    chk("R10 one write", rec_n, 1);
  endtask

  task automatic t_handoff();
    logic ok;
    flush_and_reset_rec();
    mem_ready = 1'b1;
    store(16'h0300, 32'h30000000, ok);
    store(16'h0301, 32'h30000001, ok);
    cycles(5);
    chk("R7 two writes", rec_n, 2);
    chk("R7 first mask", rec_mask[0], 4'b0001);
    chk("R7 second line", rec_line[1], 14'h0C0);
    chk("R7 second mask", rec_mask[1], 4'b0010);
    chk("R7 second data", rec_data[1], line4(0, 0, 32'h30000001, 0));
  endtask

  task automatic t_full();
    logic ok;
    flush_and_reset_rec();
    mem_ready = 1'b0;
    for (int i = 0; i < 4; i++) store(16'(16'h0500 + i * 4), 32'(i), ok);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 16'h0600; st_data = 32'h66;
    #3;
    chk("R8 stall new line", st_ready, 1'b0);
    cycles(2);
    #3;
    chk("R8 still stalled", st_ready, 1'b0);
    @(negedge clk);
    st_addr = 16'h050B; st_data = 32'h88;
    #3;
    chk("R8 merge when full", st_ready, 1'b1);
    @(posedge clk);
    #1 st_valid = 1'b0;
    @(negedge clk) mem_ready = 1'b1;
    store(16'h0600, 32'h66, ok);
    cycles(8);
    chk("R8 writes", rec_n, 5);
    chk("R5 order 0", rec_line[0], 14'h140);
    chk("R8 merged mask", rec_mask[2], 4'b1001);
    chk("R8 merged data", rec_data[2], line4(32'h88, 0, 0, 32'h2));
    chk("R8 late line", rec_line[4], 14'h180);
  endtask

  task automatic t_fence();
    logic ok;
    int seen;
    flush_and_reset_rec();
    mem_ready = 1'b0;
    store(16'h0700, 32'h70, ok);
    store(16'h0710, 32'h71, ok);
    @(negedge clk);
    fence = 1'b1;
    st_valid = 1'b1; st_addr = 16'h0720; st_data = 32'h72;
    #3;
    chk("R9 store blocked", st_ready, 1'b0);
    chk("R9 not done", fence_done, 1'b0);
    cycles(2);
    #3;
    chk("R9 still not done", fence_done, 1'b0);
    @(negedge clk) mem_ready = 1'b1;
    seen = -1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      #3;
      if (fence_done && seen < 0) begin
        seen = rec_n;
        chk("R9 empty at done", mem_valid, 1'b0);
      end
      chk("R9 blocked while fenced", st_ready, 1'b0);
    end
    chk("R9 done after all writes", seen, 2);
    @(negedge clk);
    st_valid = 1'b0; fence = 1'b0;
    cycles(3);
    chk("R9 no leaked store", rec_n, 2);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    t_reset();
    t_merge();
    t_overwrite();
    t_pso();
    t_stable();
    t_handoff();
    t_full();
    t_fence();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule